// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator with Sticky Invalid Flag

This block compares two IEEE-754 binary32 operands under one of seven relations. The relations are unordered, less-than, equal, less-or-equal, greater-than, not-equal and greater-or-equal. The 1-bit outcome is returned in bit 0 of a 32-bit result word, and the upper bits are always zero. The block owns a small floating-point status register. A compare can only ever raise the invalid-operation bit of that register. The bit is sticky: once set, it stays set until software overwrites the register through a dedicated write port.

Whether a NaN operand counts as invalid depends on the relation. The quiet relations (unordered, equal, not-equal) treat a quiet NaN as a legal operand and complain only about signalling NaNs. The ordered relations complain about any NaN. Some relations swap their operands. Less-than evaluates B < A, and greater-than evaluates A < B. Greater-or-equal is the inverse of A < B, so it reports true when the operands are unordered. When a compare raises the invalid flag, the block also raises a one-cycle exception request, but only if FPU exceptions are configured in and the exceptions-enable bit is set.

A compare is launched by pulsing `op_valid`. Its result, the status update and any exception request all appear on the clock edge that samples the request, so they are visible one cycle later.

Top module: `sp_fcmp_unit`

## Requirements
- R1: After reset, `result`, `res_valid` and `exc_req` are 0 and `stat_q` is all zeros.
- R2: `res_valid` is high in exactly the cycle after a cycle with `op_valid` high. `result[31:1]` is always zero.
- R3: Relation code 0 (unordered) returns 1 when either operand is a NaN, and 0 otherwise. It flags invalid only when an operand is a signalling NaN (exponent all ones, fraction nonzero, fraction MSB 0).
- R4: Code 1 returns B < A. Code 4 returns A < B. Code 3 returns A <= B. All three return 0 when either operand is a NaN. Ordering follows sign and magnitude, including subnormals and infinities.
- R5: Code 2 (equal) is a quiet equality in which +0 equals -0 and a NaN equals nothing. Code 5 (not-equal) is its exact inverse. Both flag invalid only for a signalling NaN.
- R6: Code 6 (greater-or-equal) returns the inverse of A < B. It therefore returns 1 when either operand is a NaN.
- R7: Codes 1, 3, 4 and 6 flag invalid when either operand is any NaN, quiet or signalling.
- R8: A raised invalid flag is ORed into status bit 4 (of 5). That bit stays set through later compares that raise nothing. A compare never changes status bits 3:0.
- R9: When `stat_wr` is high, `stat_q` loads `stat_wdata`. An invalid flag raised in the same cycle is still ORed into bit 4.
- R10: `exc_req` pulses in the cycle after a compare only if that compare raised invalid, `fpu_exc_cfg` is 1 and `exc_en` is 1.
- R11: Code 7 is reserved. It returns 0 and raises no flag and no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Launch a compare this cycle |
| op_a | input | 32 | Operand A, binary32 |
| op_b | input | 32 | Operand B, binary32 |
| rel_sel | input | 3 | Relation code (0 un, 1 lt, 2 eq, 3 le, 4 gt, 5 ne, 6 ge, 7 reserved) |
| exc_en | input | 1 | Exceptions-enable bit |
| fpu_exc_cfg | input | 1 | FPU exceptions configured in |
| stat_wr | input | 1 | Software write strobe for the status register |
| stat_wdata | input | 5 | Value written to the status register |
| result | output | 32 | Compare outcome in bit 0 |
| res_valid | output | 1 | Result qualifier, one cycle after `op_valid` |
| exc_req | output | 1 | One-cycle FPU exception request |
| stat_q | output | 5 | Status register, invalid flag in bit 4 |

## Verification
The checker assumes that every control input is a known 0 or 1 at each rising edge. It also assumes that `rel_sel` and both operands are known whenever `op_valid` is high. The checker does not rely on these inputs being held steady across cycles.

The bench drives all inputs from one task, on the falling edge, and returns every input to a defined idle value after each request. As a result, no X ever reaches the sampled edge. The vector walk writes zero to the status register in the same cycle as each compare. This isolates the invalid bit of that compare and exercises the write-then-OR ordering without the checker needing any knowledge of earlier traffic.

// File: rtl/sp_fcmp_pkg.sv
package sp_fcmp_pkg;

   // Relation codes decoded by the selector; the numeric values are the
   // externally visible encoding of rel_sel.
   typedef enum logic [2:0] {
      REL_UN  = 3'd0,
      REL_LT  = 3'd1,
      REL_EQ  = 3'd2,
      REL_LE  = 3'd3,
      REL_GT  = 3'd4,
      REL_NE  = 3'd5,
      REL_GE  = 3'd6,
      REL_RSV = 3'd7
   } rel_e;

   // Per-operand classification shared by the order core.
   typedef struct packed {
      logic sign;
      logic is_zero;
      logic is_nan;
      logic is_snan;
   } fp_class_t;

   // Raw facts produced by the order core for one operand pair.
   typedef struct packed {
      logic a_lt_b;
      logic b_lt_a;
      logic a_eq_b;
      logic unordered;
      logic any_snan;
   } fp_order_t;

endpackage

// File: rtl/sp_fcmp_classify.sv
module sp_fcmp_classify
   import sp_fcmp_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int FP_W = 1 + EXP_W + MAN_W
) (
   input  logic [FP_W-1:0]   val,
   output fp_class_t         cls,
   output logic [FP_W-2:0]   mag
);

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             exp_max;
   logic             man_nz;

   always_comb begin
      exp_f   = val[FP_W-2 -: EXP_W];
      man_f   = val[MAN_W-1:0];
      exp_max = &exp_f;
      man_nz  = |man_f;
      mag     = val[FP_W-2:0];

      cls.sign    = val[FP_W-1];
      cls.is_zero = ~|val[FP_W-2:0];
      cls.is_nan  = exp_max & man_nz;
      // A NaN whose leading fraction bit is clear is signalling.
      cls.is_snan = exp_max & man_nz & ~man_f[MAN_W-1];
   end

endmodule

// File: rtl/sp_fcmp_order.sv
module sp_fcmp_order
   import sp_fcmp_pkg::*;
#(
   parameter int MAG_W = 31
) (
   input  fp_class_t        cls_a,
   input  fp_class_t        cls_b,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   output fp_order_t        ord
);

   logic unord;
   logic both_zero;
   logic signs_differ;
   logic mag_a_lt;
   logic mag_b_lt;

   always_comb begin
      unord        = cls_a.is_nan | cls_b.is_nan;
      both_zero    = cls_a.is_zero & cls_b.is_zero;
      signs_differ = cls_a.sign ^ cls_b.sign;
      mag_a_lt     = mag_a < mag_b;
      mag_b_lt     = mag_b < mag_a;

      ord.unordered = unord;
      ord.any_snan  = cls_a.is_snan | cls_b.is_snan;

      if (unord || both_zero) begin
         ord.a_lt_b = 1'b0;
         ord.b_lt_a = 1'b0;
      end else if (signs_differ) begin
         ord.a_lt_b = cls_a.sign;
         ord.b_lt_a = cls_b.sign;
      end else if (!cls_a.sign) begin
         ord.a_lt_b = mag_a_lt;
         ord.b_lt_a = mag_b_lt;
      end else begin
         ord.a_lt_b = mag_b_lt;
         ord.b_lt_a = mag_a_lt;
      end

      ord.a_eq_b = ~unord & (both_zero | (~signs_differ & (mag_a == mag_b)));
   end

endmodule

// File: rtl/sp_fcmp_select.sv
module sp_fcmp_select
   import sp_fcmp_pkg::*;
(
   input  logic [2:0] rel_sel,
   input  fp_order_t  ord,
   output logic       hit,
   output logic       invalid
);

   rel_e rel;
   logic quiet_inv;
   logic loud_inv;

   always_comb begin
      rel       = rel_e'(rel_sel);
      quiet_inv = ord.any_snan;
      loud_inv  = ord.unordered;
      hit       = 1'b0;
      invalid   = 1'b0;
      unique case (rel)
         REL_UN:  begin hit = ord.unordered;              invalid = quiet_inv; end
         REL_LT:  begin hit = ord.b_lt_a;                 invalid = loud_inv;  end
         REL_EQ:  begin hit = ord.a_eq_b;                 invalid = quiet_inv; end
         REL_LE:  begin hit = ord.a_lt_b | ord.a_eq_b;    invalid = loud_inv;  end
         REL_GT:  begin hit = ord.a_lt_b;                 invalid = loud_inv;  end
         REL_NE:  begin hit = ~ord.a_eq_b;                invalid = quiet_inv; end
         REL_GE:  begin hit = ~ord.a_lt_b;                invalid = loud_inv;  end
         REL_RSV: begin hit = 1'b0;                       invalid = 1'b0;      end
         default: begin hit = 1'b0;                       invalid = 1'b0;      end
      endcase
   end

endmodule

// File: rtl/sp_fcmp_unit.sv
module sp_fcmp_unit
   import sp_fcmp_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int MAN_W   = 23,
   parameter int STAT_W  = 5,
   parameter int INV_BIT = 4,
   localparam int FP_W   = 1 + EXP_W + MAN_W,
   localparam int MAG_W  = FP_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [FP_W-1:0]   op_a,
   input  logic [FP_W-1:0]   op_b,
   input  logic [2:0]        rel_sel,
   input  logic              exc_en,
   input  logic              fpu_exc_cfg,
   input  logic              stat_wr,
   input  logic [STAT_W-1:0] stat_wdata,
   output logic [FP_W-1:0]   result,
   output logic              res_valid,
   output logic              exc_req,
   output logic [STAT_W-1:0] stat_q
);

   // Elaboration-time parameter checks.
   if (EXP_W < 2) begin : g_bad_exp
      $error("sp_fcmp_unit: EXP_W must be at least 2");
   end
   if (MAN_W < 2) begin : g_bad_man
      $error("sp_fcmp_unit: MAN_W must be at least 2");
   end
   if (INV_BIT >= STAT_W) begin : g_bad_inv
      $error("sp_fcmp_unit: INV_BIT must lie inside the status word");
   end

   localparam logic [STAT_W-1:0] INV_MASK = STAT_W'(1) << INV_BIT;

   logic [1:0][FP_W-1:0] operand;
   fp_class_t            cls [2];
   logic [MAG_W-1:0]     mag [2];
   fp_order_t            ord;
   logic                 hit;
   logic                 inv_raw;
   logic                 inv_now;

   assign operand[0] = op_a;
   assign operand[1] = op_b;

   for (genvar g = 0; g < 2; g++) begin : g_cls
      sp_fcmp_classify #(
         .EXP_W (EXP_W),
         .MAN_W (MAN_W)
      ) u_cls (
         .val (operand[g]),
         .cls (cls[g]),
         .mag (mag[g])
      );
   end

   sp_fcmp_order #(
      .MAG_W (MAG_W)
   ) u_order (
      .cls_a (cls[0]),
      .cls_b (cls[1]),
      .mag_a (mag[0]),
      .mag_b (mag[1]),
      .ord   (ord)
   );

   sp_fcmp_select u_select (
      .rel_sel (rel_sel),
      .ord     (ord),
      .hit     (hit),
      .invalid (inv_raw)
   );

   assign inv_now = op_valid & inv_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result    <= '0;
         res_valid <= 1'b0;
         exc_req   <= 1'b0;
      end else begin
         res_valid <= op_valid;
         exc_req   <= inv_now & fpu_exc_cfg & exc_en;
         if (op_valid) begin
            result <= FP_W'(hit);
         end
      end
   end

   // Software write takes the new value; a flag raised in the same cycle
   // is still merged so that no invalid event is lost.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
      end else begin
         stat_q <= (stat_wr ? stat_wdata : stat_q) | (inv_now ? INV_MASK : '0);
      end
   end

endmodule

// File: rtl/sp_fcmp_checker.sv
module sp_fcmp_checker #(
   parameter int FP_W    = 32,
   parameter int STAT_W  = 5,
   parameter int INV_BIT = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [2:0]        rel_sel,
   input logic              exc_en,
   input logic              fpu_exc_cfg,
   input logic              stat_wr,
   input logic [STAT_W-1:0] stat_wdata,
   input logic [FP_W-1:0]   result,
   input logic              res_valid,
   input logic              exc_req,
   input logic [STAT_W-1:0] stat_q
);

   localparam logic [STAT_W-1:0] KEEP = ~(STAT_W'(1) << INV_BIT);

   // R2: a result follows every request and only a request
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> res_valid);
   a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !res_valid);
   // R2: only bit 0 of the result word carries information
   a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      result[FP_W-1:1] == '0);
   // R8: sticky invalid bit survives cycles without a software write
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_wr && stat_q[INV_BIT]) |=> stat_q[INV_BIT]);
   // R8: compares leave the other status bits alone
   a_r8_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr |=> ((stat_q & KEEP) == $past(stat_q & KEEP)));
   // R9: software write lands in the non-invalid bits
   a_r9_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> ((stat_q & KEEP) == $past(stat_wdata & KEEP)));
   // R10: no exception without configuration, enable and a request
   a_r10_exc_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && exc_en && fpu_exc_cfg) |=> !exc_req);
   // R10: an exception always comes with the invalid flag set
   a_r10_exc_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> stat_q[INV_BIT]);
   // R11: reserved code yields zero and no exception
   a_r11_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && rel_sel == 3'd7) |=> (result == '0 && !exc_req));

endmodule

bind sp_fcmp_unit sp_fcmp_checker #(
   .FP_W    (FP_W),
   .STAT_W  (STAT_W),
   .INV_BIT (INV_BIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_valid    (op_valid),
   .rel_sel     (rel_sel),
   .exc_en      (exc_en),
   .fpu_exc_cfg (fpu_exc_cfg),
   .stat_wr     (stat_wr),
   .stat_wdata  (stat_wdata),
   .result      (result),
   .res_valid   (res_valid),
   .exc_req     (exc_req),
   .stat_q      (stat_q)
);

// File: tb/sp_fcmp_unit_test.sv
module sp_fcmp_unit_test;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 27;

   // Vector layout: {rel[2:0], a[31:0], b[31:0], expected bit, expected invalid}
   localparam logic [31:0] P1  = 32'h3F80_0000;
   localparam logic [31:0] P2  = 32'h4000_0000;
   localparam logic [31:0] N1  = 32'hBF80_0000;
   localparam logic [31:0] N2  = 32'hC000_0000;
   localparam logic [31:0] PZ  = 32'h0000_0000;
   localparam logic [31:0] NZ  = 32'h8000_0000;
   localparam logic [31:0] QN  = 32'h7FC0_0000;
   localparam logic [31:0] SN  = 32'h7F80_0001;
   localparam logic [31:0] PI  = 32'h7F80_0000;
   localparam logic [31:0] NI  = 32'hFF80_0000;
   localparam logic [31:0] DN  = 32'h0000_0001;

   localparam logic [68:0] VEC [NV] = '{
      {3'd0, P1, P2, 1'b0, 1'b0},   // R3
      {3'd0, QN, P1, 1'b1, 1'b0},   // R3 quiet NaN, no flag
      {3'd0, P1, SN, 1'b1, 1'b1},   // R3 signalling NaN
      {3'd1, P2, P1, 1'b1, 1'b0},   // R4 B<A
      {3'd1, P1, P2, 1'b0, 1'b0},   // R4
      {3'd1, QN, P1, 1'b0, 1'b1},   // R4 R7
      {3'd4, P1, P2, 1'b1, 1'b0},   // R4 A<B
      {3'd4, N1, N2, 1'b0, 1'b0},   // R4 negatives
      {3'd4, N2, N1, 1'b1, 1'b0},   // R4 negatives
      {3'd3, P1, P1, 1'b1, 1'b0},   // R4 A<=B equal
      {3'd3, NZ, PZ, 1'b1, 1'b0},   // R4 signed zeros
      {3'd3, P2, P1, 1'b0, 1'b0},   // R4
      {3'd3, QN, QN, 1'b0, 1'b1},   // R7 quiet NaN ordered
      {3'd2, PZ, NZ, 1'b1, 1'b0},   // R5 +0 == -0
      {3'd2, P1, N1, 1'b0, 1'b0},   // R5
      {3'd2, QN, QN, 1'b0, 1'b0},   // R5 quiet NaN no flag
      {3'd2, SN, P1, 1'b0, 1'b1},   // R5 signalling flags
      {3'd5, P1, P2, 1'b1, 1'b0},   // R5 ne
      {3'd5, QN, P1, 1'b1, 1'b0},   // R5 ne NaN
      {3'd5, PZ, NZ, 1'b0, 1'b0},   // R5 ne zeros
      {3'd6, P1, P2, 1'b0, 1'b0},   // R6
      {3'd6, P2, P1, 1'b1, 1'b0},   // R6
      {3'd6, QN, P1, 1'b1, 1'b1},   // R6 R7 unordered ge
      {3'd6, NI, PI, 1'b0, 1'b0},   // R6 infinities
      {3'd1, P1, DN, 1'b1, 1'b0},   // R4 subnormal
      {3'd4, NZ, DN, 1'b1, 1'b0},   // R4 -0 < tiny
      {3'd7, P1, P2, 1'b0, 1'b0}    // R11 reserved
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [2:0]  rel_sel = '0;
   logic        exc_en = 1'b0;
   logic        fpu_exc_cfg = 1'b0;
   logic        stat_wr = 1'b0;
   logic [4:0]  stat_wdata = '0;
   logic [31:0] result;
   logic        res_valid;
   logic        exc_req;
   logic [4:0]  stat_q;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sp_fcmp_unit uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_valid    (op_valid),
      .op_a        (op_a),
      .op_b        (op_b),
      .rel_sel     (rel_sel),
      .exc_en      (exc_en),
      .fpu_exc_cfg (fpu_exc_cfg),
      .stat_wr     (stat_wr),
      .stat_wdata  (stat_wdata),
      .result      (result),
      .res_valid   (res_valid),
      .exc_req     (exc_req),
      .stat_q      (stat_q)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One compare; outputs are sampled on the falling edge after capture.
   task automatic run_op(input logic [2:0] rel, input logic [31:0] a, input logic [31:0] b,
                         input logic wr, input logic [4:0] wd,
                         input logic en, input logic cfg);
      @(negedge clk);
      op_valid = 1'b1; rel_sel = rel; op_a = a; op_b = b;
      stat_wr = wr; stat_wdata = wd; exc_en = en; fpu_exc_cfg = cfg;
      @(negedge clk);
      op_valid = 1'b0; stat_wr = 1'b0; stat_wdata = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 result", result, 32'h0);
      check("R1 res_valid", {31'h0, res_valid}, 32'h0);
      check("R1 exc_req", {31'h0, exc_req}, 32'h0);
      check("R1 stat_q", {27'h0, stat_q}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector walk: status cleared by a write in the same cycle (R9),
      // so bit 4 reflects exactly this compare's invalid flag (R8).
      for (int i = 0; i < NV; i++) begin
         run_op(VEC[i][68:66], VEC[i][65:34], VEC[i][33:2], 1'b1, 5'h0, 1'b1, 1'b1);
         check($sformatf("R3-R7 vec%0d result", i), result, {31'h0, VEC[i][1]});
         check($sformatf("R8 vec%0d stat", i), {27'h0, stat_q}, {27'h0, VEC[i][0], 4'h0});
         check($sformatf("R10 vec%0d exc", i), {31'h0, exc_req}, {31'h0, VEC[i][0]});
         check($sformatf("R2 vec%0d valid", i), {31'h0, res_valid}, 32'h1);
      end

      // R2: idle cycle drops res_valid
      @(negedge clk);
      check("R2 idle valid", {31'h0, res_valid}, 32'h0);

      // R9: software write loads all bits
      @(negedge clk);
      stat_wr = 1'b1; stat_wdata = 5'b01011;
      @(negedge clk);
      stat_wr = 1'b0; stat_wdata = '0;
      check("R9 write", {27'h0, stat_q}, 32'h0000_000B);

      // R8: invalid merges into bit 4 without touching bits 3:0
      run_op(3'd1, QN, P1, 1'b0, 5'h0, 1'b0, 1'b0);
      check("R8 merge", {27'h0, stat_q}, 32'h0000_001B);
      // R8: sticky through a clean compare
      run_op(3'd2, P1, P1, 1'b0, 5'h0, 1'b0, 1'b0);
      check("R8 sticky", {27'h0, stat_q}, 32'h0000_001B);
      check("R5 eq 1==1", result, 32'h1);

      // R10: configured off -> no request, flag still set
      run_op(3'd0, SN, P1, 1'b1, 5'h0, 1'b1, 1'b0);
      check("R10 cfg off exc", {31'h0, exc_req}, 32'h0);
      check("R10 cfg off stat", {27'h0, stat_q}, 32'h0000_0010);
      // R10: enable off -> no request
      run_op(3'd3, QN, P1, 1'b1, 5'h0, 1'b0, 1'b1);
      check("R10 en off exc", {31'h0, exc_req}, 32'h0);
      // R10: request lasts one cycle
      run_op(3'd4, SN, SN, 1'b1, 5'h0, 1'b1, 1'b1);
      check("R10 exc on", {31'h0, exc_req}, 32'h1);
      @(negedge clk);
      check("R10 exc pulse", {31'h0, exc_req}, 32'h0);

      // R11: reserved code with a NaN raises nothing
      run_op(3'd7, SN, QN, 1'b1, 5'h0, 1'b1, 1'b1);
      check("R11 stat", {27'h0, stat_q}, 32'h0);
      check("R11 exc", {31'h0, exc_req}, 32'h0);

      // R1: reset clears sticky state
      run_op(3'd1, QN, P1, 1'b0, 5'h0, 1'b1, 1'b1);
      rst_n = 1'b0;
      #1;
      check("R1 reset stat", {27'h0, stat_q}, 32'h0);
      check("R1 reset result", result, 32'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule